// File: doc/BRIEF.md
# Single-Cycle Word RISC Core

This block is a 32-bit processor core that completes one instruction on every clock edge. It holds its own instruction store and data store as word arrays. Operands are fetched combinationally from the program counter, and the instruction fields are decoded by a fixed opcode table. The result is committed to the register file or the data store at the next rising edge. The supported set covers five register-to-register operations (add, subtract, and, or, signed set-less-than), word load, word store, branch-if-equal and an absolute jump inside the current 256 MB region.

Both stores are filled through a load stream made of `ld_valid`, `ld_ready`, a target select, a word index and a data word. The core applies back-pressure on this stream by holding `ld_ready` low whenever it is running. A word is accepted only on a rising edge where `ld_valid` and `ld_ready` are both high, and `ld_ready` simply follows the reset input. To boot a program, the integrator holds reset, streams the program and its initial data, and then releases reset. Trace outputs give the current PC and, in the same cycle, the register write that the current instruction will commit at the next edge.

Top module: `sc_core`

## Requirements
- R1: Reset is synchronous and active high. A rising edge with `rst` high sets the PC to 0, and the PC stays at 0 while `rst` remains high. Reset leaves the register file and the data store unchanged.
- R2: The instruction word is split into fields as follows. The opcode is bits 31-26, source A is bits 25-21, source B/target is bits 20-16, the destination is bits 15-11, the function code is bits 5-0, the 16-bit immediate is bits 15-0 and the jump field is bits 25-0. The opcodes are: register op 000000, load 100011, store 101011, branch 000100, jump 000010.
- R3: A register op writes its result to the destination register. The function code selects the operation: 100000 adds, 100010 subtracts B from A, 100100 is bitwise and, 100101 is bitwise or.
- R4: Function code 101010 writes 1 when A is less than B as a signed two's-complement value, and 0 otherwise.
- R5: A load forms its address as A plus the sign-extended immediate. It reads the data word at index address[k+1:2] and writes that word to the target register.
- R6: A store writes the target register's value to the data word at index A plus the sign-extended immediate (bits k+1:2). A store writes no register.
- R7: A branch is taken when A equals B. The taken target is PC+4 plus the sign-extended immediate shifted left by two, so both forward and backward targets are reachable. A branch that is not taken goes to PC+4, and a branch writes no register.
- R8: A jump loads the PC with bits 31-28 of PC+4, then jump field bits 25-0, then two zero bits. A jump writes nothing.
- R9: Register 0 always reads as zero. A write aimed at register 0 is dropped and is not shown on the trace port.
- R10: An opcode outside the set writes neither a register nor memory and advances the PC by 4.
- R11: `ld_ready` equals `rst`. On an edge with both `ld_valid` and `ld_ready` high, the data word is stored at index `ld_addr`, into the data store when `ld_to_data` is 1 and into the instruction store when it is 0. While the core runs, a presented word is discarded.
- R12: `dbg_wr_en`, `dbg_wr_addr` and `dbg_wr_data` show, in the cycle before the edge, the register write of the instruction at `dbg_pc`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous reset, active high |
| ld_valid | input | 1 | Load stream word present |
| ld_ready | output | 1 | Load stream accepts (high only in reset) |
| ld_to_data | input | 1 | 1 = data store, 0 = instruction store |
| ld_addr | input | clog2(MEM_WORDS) | Word index for the load |
| ld_data | input | 32 | Word to store |
| dbg_pc | output | 32 | Current program counter |
| dbg_wr_en | output | 1 | A register write commits at the next edge |
| dbg_wr_addr | output | 5 | Register being written |
| dbg_wr_data | output | 32 | Value being written |

## Verification
The bench builds the core with its default of 64 words per store. At that depth, both the instruction index and the data index wrap cleanly, and a load with a negative offset from a nonzero base is reachable. That depth also holds a program long enough to include a forward taken branch, a non-taken branch, an undefined opcode, a jump and a self-looping backward branch. It cannot reach PC values that carry nonzero bits 31-28, so the region part of the jump target is only shown to be preserved as zero. A reset issued mid-run, followed by a reload, shows that data stored before the reset survives and that a load word offered while the core was running left no trace.

// File: rtl/sc_pkg.sv
package sc_pkg;
  localparam int XLEN = 32;

  localparam logic [5:0] OPC_REG   = 6'b000000;
  localparam logic [5:0] OPC_LOAD  = 6'b100011;
  localparam logic [5:0] OPC_STORE = 6'b101011;
  localparam logic [5:0] OPC_BEQ   = 6'b000100;
  localparam logic [5:0] OPC_JUMP  = 6'b000010;

  localparam logic [5:0] FN_ADD = 6'b100000;
  localparam logic [5:0] FN_SUB = 6'b100010;
  localparam logic [5:0] FN_AND = 6'b100100;
  localparam logic [5:0] FN_OR  = 6'b100101;
  localparam logic [5:0] FN_SLT = 6'b101010;

  typedef enum logic [2:0] {
    ALU_ADD, ALU_SUB, ALU_AND, ALU_OR, ALU_SLT
  } alu_fn_e;

  typedef struct packed {
    logic       dst_is_rd;
    logic       b_is_imm;
    logic       wb_from_mem;
    logic       reg_we;
    logic       mem_re;
    logic       mem_we;
    logic       branch;
    logic       jump;
    logic [1:0] alu_op;
  } ctrl_t;
endpackage

// File: rtl/sc_decode.sv
module sc_decode
  import sc_pkg::*;
(
  input  logic        clk,
  input  logic        rst,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  output ctrl_t       ctrl,
  output alu_fn_e     alu_fn
);
  always_comb begin
    ctrl = '0;
    unique case (opcode)
      OPC_REG: begin
        ctrl.dst_is_rd = 1'b1;
        ctrl.reg_we    = 1'b1;
        ctrl.alu_op    = 2'b10;
      end
      OPC_LOAD: begin
        ctrl.b_is_imm    = 1'b1;
        ctrl.wb_from_mem = 1'b1;
        ctrl.reg_we      = 1'b1;
        ctrl.mem_re      = 1'b1;
      end
      OPC_STORE: begin
        ctrl.b_is_imm = 1'b1;
        ctrl.mem_we   = 1'b1;
      end
      OPC_BEQ: begin
        ctrl.branch = 1'b1;
        ctrl.alu_op = 2'b01;
      end
      OPC_JUMP: ctrl.jump = 1'b1;
      default: ctrl = '0;
    endcase
  end

  always_comb begin
    unique case (ctrl.alu_op)
      2'b00: alu_fn = ALU_ADD;
      2'b01: alu_fn = ALU_SUB;
      default: begin
        case (funct)
          FN_SUB:  alu_fn = ALU_SUB;
          FN_AND:  alu_fn = ALU_AND;
          FN_OR:   alu_fn = ALU_OR;
          FN_SLT:  alu_fn = ALU_SLT;
          default: alu_fn = ALU_ADD;
        endcase
      end
    endcase
  end

  AST_ONE_SIDE_EFFECT: assert property (@(posedge clk) disable iff (rst)
    $onehot0({ctrl.reg_we & ~ctrl.wb_from_mem, ctrl.mem_we, ctrl.branch, ctrl.jump})); // R6
  AST_NO_READ_AND_WRITE: assert property (@(posedge clk) disable iff (rst)
    !(ctrl.mem_re && ctrl.mem_we)); // R5
endmodule

// File: rtl/sc_alu.sv
module sc_alu
  import sc_pkg::*;
#(
  parameter int W = XLEN
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  alu_fn_e      fn,
  output logic [W-1:0] y,
  output logic         zero
);
  always_comb begin
    unique case (fn)
      ALU_SUB: y = a - b;
      ALU_AND: y = a & b;
      ALU_OR:  y = a | b;
      ALU_SLT: y = {{(W-1){1'b0}}, ($signed(a) < $signed(b))};
      default: y = a + b;
    endcase
  end
  assign zero = (y == '0);
endmodule

// File: rtl/sc_regfile.sv
module sc_regfile #(
  parameter int NREGS = 32,
  parameter int W     = 32,
  localparam int AW   = $clog2(NREGS)
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [W-1:0]  wdata,
  input  logic [AW-1:0] ra_a,
  input  logic [AW-1:0] ra_b,
  output logic [W-1:0]  rd_a,
  output logic [W-1:0]  rd_b
);
  logic [W-1:0] regs [NREGS];

  always_ff @(posedge clk) begin
    if (we && waddr != '0) regs[waddr] <= wdata;
  end

  assign rd_a = (ra_a == '0) ? '0 : regs[ra_a];
  assign rd_b = (ra_b == '0) ? '0 : regs[ra_b];

  AST_ZERO_REG_READ: assert property (@(posedge clk) disable iff (rst)
    (ra_b == '0) |-> (rd_b == '0)); // R9
endmodule

// File: rtl/sc_core.sv
module sc_core
  import sc_pkg::*;
#(
  parameter int MEM_WORDS = 64
) (
  input  logic                         clk,
  input  logic                         rst,
  input  logic                         ld_valid,
  output logic                         ld_ready,
  input  logic                         ld_to_data,
  input  logic [$clog2(MEM_WORDS)-1:0] ld_addr,
  input  logic [31:0]                  ld_data,
  output logic [31:0]                  dbg_pc,
  output logic                         dbg_wr_en,
  output logic [4:0]                   dbg_wr_addr,
  output logic [31:0]                  dbg_wr_data
);
  localparam int IDX_W = $clog2(MEM_WORDS);

  logic [XLEN-1:0] pc, pc_plus4, pc_next, br_target, jmp_target;
  logic [XLEN-1:0] instr, simm, op_a, op_b, alu_b, alu_y, mem_rdata, wb_data;
  logic [XLEN-1:0] imem [MEM_WORDS];
  logic [XLEN-1:0] dmem [MEM_WORDS];
  logic [4:0]      wr_reg;
  logic            alu_zero, take_branch, ld_fire;
  ctrl_t           ctrl;
  alu_fn_e         alu_fn;

  assign ld_ready = rst;
  assign ld_fire  = ld_valid & ld_ready;

  // instruction store: written only through the load stream
  always_ff @(posedge clk) begin
    if (ld_fire && !ld_to_data) imem[ld_addr] <= ld_data;
  end
  assign instr = imem[pc[IDX_W+1:2]];

  sc_decode u_dec (
    .clk(clk), .rst(rst),
    .opcode(instr[31:26]), .funct(instr[5:0]),
    .ctrl(ctrl), .alu_fn(alu_fn)
  );

  assign wr_reg = ctrl.dst_is_rd ? instr[15:11] : instr[20:16];
  assign simm   = {{16{instr[15]}}, instr[15:0]};

  sc_regfile #(.NREGS(32), .W(XLEN)) u_rf (
    .clk(clk), .rst(rst),
    .we(ctrl.reg_we & ~rst), .waddr(wr_reg), .wdata(wb_data),
    .ra_a(instr[25:21]), .ra_b(instr[20:16]),
    .rd_a(op_a), .rd_b(op_b)
  );

  assign alu_b = ctrl.b_is_imm ? simm : op_b;

  sc_alu #(.W(XLEN)) u_alu (
    .a(op_a), .b(alu_b), .fn(alu_fn), .y(alu_y), .zero(alu_zero)
  );

  // data store: load stream during reset, store instructions while running
  always_ff @(posedge clk) begin
    if (ld_fire && ld_to_data)        dmem[ld_addr] <= ld_data;
    else if (!rst && ctrl.mem_we)     dmem[alu_y[IDX_W+1:2]] <= op_b;
  end
  assign mem_rdata = ctrl.mem_re ? dmem[alu_y[IDX_W+1:2]] : '0;
  assign wb_data   = ctrl.wb_from_mem ? mem_rdata : alu_y;

  assign pc_plus4    = pc + 32'd4;
  assign br_target   = pc_plus4 + {simm[XLEN-3:0], 2'b00};
  assign jmp_target  = {pc_plus4[31:28], instr[25:0], 2'b00};
  assign take_branch = ctrl.branch & alu_zero;

  always_comb begin
    if (ctrl.jump)        pc_next = jmp_target;
    else if (take_branch) pc_next = br_target;
    else                  pc_next = pc_plus4;
  end

  always_ff @(posedge clk) begin
    if (rst) pc <= '0;
    else     pc <= pc_next;
  end

  assign dbg_pc      = pc;
  assign dbg_wr_en   = ctrl.reg_we && (wr_reg != 5'd0);
  assign dbg_wr_addr = wr_reg;
  assign dbg_wr_data = wb_data;

  logic seen_edge;
  always_ff @(posedge clk) seen_edge <= 1'b1;

  AST_PC_CLEARED: assert property (@(posedge clk)
    (seen_edge && $past(rst)) |-> (pc == '0)); // R1
  AST_PC_WORD_ALIGNED: assert property (@(posedge clk) disable iff (rst)
    pc[1:0] == 2'b00); // R7
  AST_SEQUENTIAL_STEP: assert property (@(posedge clk) disable iff (rst)
    (!ctrl.jump && !ctrl.branch) |=> (pc == $past(pc) + 32'd4)); // R10
  AST_NO_R0_TRACE: assert property (@(posedge clk) disable iff (rst)
    dbg_wr_en |-> (dbg_wr_addr != 5'd0)); // R9
  AST_NO_LOAD_WHILE_RUNNING: assert property (@(posedge clk)
    (seen_edge && !rst && $past(!rst) && ctrl.jump) |=> $stable(imem[0])); // R11
endmodule

// File: tb/sim_sc_core.sv
module sim_sc_core;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        ld_valid = 1'b0;
  logic        ld_ready;
  logic        ld_to_data = 1'b0;
  logic [5:0]  ld_addr = '0;
  logic [31:0] ld_data = '0;
  logic [31:0] dbg_pc, dbg_wr_data;
  logic        dbg_wr_en;
  logic [4:0]  dbg_wr_addr;

  int n_checks = 0;
  int n_fail   = 0;

  always #2 clk = ~clk;

  sc_core #(.MEM_WORDS(64)) u0 (
    .clk(clk), .rst(rst), .ld_valid(ld_valid), .ld_ready(ld_ready),
    .ld_to_data(ld_to_data), .ld_addr(ld_addr), .ld_data(ld_data),
    .dbg_pc(dbg_pc), .dbg_wr_en(dbg_wr_en), .dbg_wr_addr(dbg_wr_addr),
    .dbg_wr_data(dbg_wr_data)
  );

  // R2 encodings
  function automatic logic [31:0] enc_r(input int rs, input int rt, input int rd, input logic [5:0] fn);
    return {6'b000000, 5'(rs), 5'(rt), 5'(rd), 5'd0, fn};
  endfunction
  function automatic logic [31:0] enc_i(input logic [5:0] op, input int rs, input int rt, input logic [15:0] imm);
    return {op, 5'(rs), 5'(rt), imm};
  endfunction
  localparam logic [5:0] LW = 6'b100011, SW = 6'b101011, BEQ = 6'b000100;

  typedef struct packed {
    logic [31:0] pc;
    logic        we;
    logic [4:0]  wa;
    logic [31:0] wd;
  } exp_t;

  localparam int NSTEP = 19;
  localparam exp_t EXP [NSTEP] = '{
    '{32'h00, 1'b1, 5'd1,  32'd5},        // R5 lw
    '{32'h04, 1'b1, 5'd2,  32'hFFFFFFFD}, // R5 lw
    '{32'h08, 1'b1, 5'd3,  32'd2},        // R3 add
    '{32'h0C, 1'b1, 5'd4,  32'd8},        // R3 sub
    '{32'h10, 1'b1, 5'd5,  32'd1},        // R4 slt true
    '{32'h14, 1'b1, 5'd6,  32'd0},        // R4 slt false
    '{32'h18, 1'b1, 5'd7,  32'd5},        // R3 and
    '{32'h1C, 1'b1, 5'd8,  32'hFFFFFFFD}, // R3 or
    '{32'h20, 1'b0, 5'd0,  32'd0},        // R6 sw
    '{32'h24, 1'b1, 5'd9,  32'd8},        // R6 readback
    '{32'h28, 1'b0, 5'd0,  32'd0},        // R9 write r0
    '{32'h2C, 1'b1, 5'd10, 32'd8},        // R9 r0 reads 0
    '{32'h30, 1'b0, 5'd0,  32'd0},        // R7 not taken
    '{32'h34, 1'b0, 5'd0,  32'd0},        // R7 taken fwd
    '{32'h40, 1'b0, 5'd0,  32'd0},        // R10 unknown op
    '{32'h44, 1'b1, 5'd11, 32'hFFFFFFFD}, // R5 negative offset
    '{32'h48, 1'b0, 5'd0,  32'd0},        // R8 jump
    '{32'h58, 1'b0, 5'd0,  32'd0},        // R7 backward self loop
    '{32'h58, 1'b0, 5'd0,  32'd0}         // R7 stays
  };

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    n_checks++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic load_word(input logic to_data, input int idx, input logic [31:0] w);
    @(negedge clk);
    ld_valid = 1'b1; ld_to_data = to_data; ld_addr = 6'(idx); ld_data = w;
    @(negedge clk);
    ld_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    n_fail++;
    $display("FAIL watchdog actual=timeout expected=finish");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end

  initial begin
    repeat (2) @(negedge clk);
    chk("R1 reset pc", dbg_pc, 32'h0);
    chk("R11 ready in reset", 32'(ld_ready), 32'd1);

    load_word(1'b1, 0, 32'd5);
    load_word(1'b1, 1, 32'hFFFFFFFD);
    load_word(1'b0, 0,  enc_i(LW, 0, 1, 16'd0));
    load_word(1'b0, 1,  enc_i(LW, 0, 2, 16'd4));
    load_word(1'b0, 2,  enc_r(1, 2, 3, 6'b100000));
    load_word(1'b0, 3,  enc_r(1, 2, 4, 6'b100010));
    load_word(1'b0, 4,  enc_r(2, 1, 5, 6'b101010));
    load_word(1'b0, 5,  enc_r(1, 2, 6, 6'b101010));
    load_word(1'b0, 6,  enc_r(1, 2, 7, 6'b100100));
    load_word(1'b0, 7,  enc_r(1, 2, 8, 6'b100101));
    load_word(1'b0, 8,  enc_i(SW, 0, 4, 16'd12));
    load_word(1'b0, 9,  enc_i(LW, 0, 9, 16'd12));
    load_word(1'b0, 10, enc_r(1, 1, 0, 6'b100000));
    load_word(1'b0, 11, enc_r(0, 9, 10, 6'b100000));
    load_word(1'b0, 12, enc_i(BEQ, 1, 2, 16'd5));
    load_word(1'b0, 13, enc_i(BEQ, 4, 9, 16'd2));
    load_word(1'b0, 14, enc_r(1, 1, 11, 6'b100000));
    load_word(1'b0, 15, enc_r(1, 1, 11, 6'b100000));
    load_word(1'b0, 16, 32'hFC21FFFF);
    load_word(1'b0, 17, enc_i(LW, 9, 11, 16'hFFFC));
    load_word(1'b0, 18, {6'b000010, 26'h16});
    for (int k = 19; k < 22; k++) load_word(1'b0, k, enc_r(1, 1, 12, 6'b100000));
    load_word(1'b0, 22, enc_i(BEQ, 0, 0, 16'hFFFF));

    chk("R1 pc held in reset", dbg_pc, 32'h0);

    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 not ready when running", 32'(ld_ready), 32'd0);
    for (int i = 0; i < NSTEP; i++) begin
      if (i != 0) begin @(negedge clk); #1; end
      chk($sformatf("R12 step %0d pc", i), dbg_pc, EXP[i].pc);
      chk($sformatf("R12 step %0d wr_en", i), 32'(dbg_wr_en), 32'(EXP[i].we));
      if (EXP[i].we) begin
        chk($sformatf("R12 step %0d wr_addr", i), 32'(dbg_wr_addr), 32'(EXP[i].wa));
        chk($sformatf("R12 step %0d wr_data", i), dbg_wr_data, EXP[i].wd);
      end
      if (i == 9) begin
        // attempted load while running: must be discarded (R11)
        ld_valid = 1'b1; ld_to_data = 1'b1; ld_addr = 6'd3; ld_data = 32'h77;
      end
      if (i == 10) ld_valid = 1'b0;
    end

    // R8 jump upper region bits are zero here
    chk("R8 jump region", {28'd0, dbg_pc[31:28]}, 32'd0);

    // mid-run reset
    rst = 1'b1;
    @(negedge clk); #1;
    chk("R1 mid-run reset pc", dbg_pc, 32'h0);
    load_word(1'b0, 0, enc_i(LW, 0, 13, 16'd12));
    @(negedge clk);
    rst = 1'b0;
    #1;
    chk("R11 discarded load / R1 data kept wr_addr", 32'(dbg_wr_addr), 32'd13);
    chk("R11 discarded load / R1 data kept wr_data", dbg_wr_data, 32'd8);
    @(negedge clk); #1;
    chk("R2 r13 readback via r0-based load pc", dbg_pc, 32'h4);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_checks, n_fail);
    $finish;
  end
endmodule